// File: doc/BRIEF.md
# RC Time-Constant Calibration Controller

This block is the digital half of an automatic tuning loop for an active-RC filter whose capacitance is set by a switched capacitor array. It sequences a replica integrator through three phases. In the clear phase both integrator switches are closed, which parks the integrator output at common mode. In the integrate phase the clear switch opens and the input switch stays closed, so the output ramps with a slope set by R and C. In the compare phase both switches open, the ramp is held, and an external comparator reports whether the held voltage is above a reference. The integrate window is a fixed count of cycles of the accurate reference clock that drives the block, so the ramp height measures the actual RC product.

Each comparator verdict moves a capacitor code one step. A ramp that ended above the reference means the capacitance is too small, so the code goes up. A ramp that ended below it means the capacitance is too large, so the code goes down. The same code drives the replica array and the filter's capacitor banks. A separate one-hot resistor select picks one of several bandwidth settings. Calibration starts from mid-scale on a start pulse or on any change of the requested band. It stops when the step direction has reversed a set number of times. At that point the code is frozen and a done flag is raised.

Top module: `rctune_ctrl`

## Requirements
- R1: After reset the block is idle: `ccode` is 32 (mid-scale), `rsel` is 4'b0001, `done` is 0, `ph_int` and `ph_cmp` are 0, and `sw_clr` and `sw_run` are both 1.
- R2: The first clock edge that sees `start` high sets `ccode` to 32 and enters the clear phase for RST_CYC (default 2) cycles, with `ph_int`=1, `sw_clr`=1 and `sw_run`=1.
- R3: After the clear phase comes the integrate phase for INT_CYC (default 16) cycles, with `ph_int`=1, `sw_clr`=0 and `sw_run`=1. `ph_int` and `ph_cmp` are never high together, and `sw_clr` is never high while `sw_run` is low.
- R4: After the integrate phase comes a compare phase of exactly one cycle, with `ph_cmp`=1, `ph_int`=0 and both switches 0. `cmp_hi` is sampled at the edge that ends this cycle, and the clear phase follows unless calibration has finished.
- R5: A `cmp_hi` of 1 in the compare phase raises `ccode` by one, and a 0 lowers it by one. `ccode` changes at no other time except a restart.
- R6: `ccode` saturates at 63 when stepping up and at 0 when stepping down. It never wraps.
- R7: A reversal is a compare decision whose direction differs from the previous decision since the last restart. On the ALT_LIM-th reversal (default 4) the step is applied and the block enters done: `done`=1, `ph_int`=`ph_cmp`=0, both switches 1, and `ccode` held until the next restart.
- R8: `rsel` is one-hot. Bit i is high when the latched band is i.
- R9: A change of `band_sel` from the latched band has the same effect as `start`, in any state. The new band appears on `rsel` at the same edge.
- R10: `start` during a running calibration or while done restarts calibration from mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Accurate reference clock; the integrate window is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart calibration |
| band_sel | input | 2 | Requested bandwidth setting, 0 to 3 |
| cmp_hi | input | 1 | Comparator result: held ramp above the reference |
| ccode | output | 6 | Capacitor array code, shared by the replica and the filter banks |
| rsel | output | 4 | One-hot resistor branch select |
| ph_int | output | 1 | Integrate phase (clear and ramp sub-phases) |
| ph_cmp | output | 1 | Compare phase |
| sw_clr | output | 1 | Integrator clear switch; high shorts the integrator to common mode |
| sw_run | output | 1 | Integrator input switch; high connects the reference to the integrator |
| done | output | 1 | Calibration converged; code frozen |

## Verification
The comparator is modelled as a first-order RC ramp. The ramp height is inversely proportional to a fixed main capacitance plus the code, and each band has its own crossing code. The crossing codes sit above and below mid-scale, so both upward and downward approaches are exercised, and each run must settle on the two codes around its crossing. A comparator forced high and then forced low drives the code into the top and bottom rails and shows that it saturates and that done never asserts without reversals. Band changes and start pulses are applied mid-ramp and while done, which distinguishes a clean restart from a code or phase counter that carries over.

// File: rtl/rctune_pkg.sv
package rctune_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CLR  = 3'd1,
      PH_INT  = 3'd2,
      PH_CMP  = 3'd3,
      PH_DONE = 3'd4
   } tune_ph_e;

   // outputs driven to the analog side for one phase: {ph_int, ph_cmp, sw_clr, sw_run}
   function automatic logic [3:0] phase_drive(tune_ph_e ph);
      case (ph)
         PH_CLR:  phase_drive = 4'b1011;
         PH_INT:  phase_drive = 4'b1001;
         PH_CMP:  phase_drive = 4'b0100;
         default: phase_drive = 4'b0011;
      endcase
   endfunction

endpackage

// File: rtl/rctune_seq.sv
module rctune_seq
   import rctune_pkg::*;
#(
   parameter int INT_CYC = 16,
   parameter int RST_CYC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  logic     conv,
   output tune_ph_e ph,
   output logic     decide
);
   localparam int LMAX  = (INT_CYC > RST_CYC) ? INT_CYC : RST_CYC;
   localparam int CNT_W = $clog2(LMAX + 1);
   localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(RST_CYC - 1);
   localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (restart) begin
         ph  <= PH_CLR;
         cnt <= '0;
      end else begin
         case (ph)
            PH_CLR: begin
               if (cnt == CLR_LAST) begin
                  ph  <= PH_INT;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_INT: begin
               if (cnt == INT_LAST) begin
                  ph  <= PH_CMP;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_CMP: begin
               ph  <= conv ? PH_DONE : PH_CLR;
               cnt <= '0;
            end
            default: cnt <= '0;
         endcase
      end
   end

   assign decide = (ph == PH_CMP) && !restart;

endmodule

// File: rtl/rctune_code.sv
module rctune_code #(
   parameter int CODE_W  = 6,
   parameter int ALT_LIM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              decide,
   input  logic              up,
   output logic [CODE_W-1:0] code,
   output logic              conv
);
   localparam int ALT_W = $clog2(ALT_LIM + 1);
   localparam logic [CODE_W-1:0] MAXC = '1;
   localparam logic [CODE_W-1:0] MIDC = CODE_W'(1) << (CODE_W - 1);
   localparam logic [ALT_W-1:0]  ALT_LAST = ALT_W'(ALT_LIM - 1);

   logic             have_dir;
   logic             last_up;
   logic [ALT_W-1:0] alt_cnt;
   logic             flip;

   assign flip = have_dir && (last_up != up);
   assign conv = decide && flip && (alt_cnt == ALT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         code     <= MIDC;
         have_dir <= 1'b0;
         last_up  <= 1'b0;
         alt_cnt  <= '0;
      end else if (decide) begin
         if (up) begin
            if (code != MAXC) code <= code + 1'b1;
         end else begin
            if (code != '0) code <= code - 1'b1;
         end
         have_dir <= 1'b1;
         last_up  <= up;
         if (flip) alt_cnt <= alt_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rctune_band.sv
module rctune_band #(
   parameter int BANDS  = 4,
   parameter int BSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BSEL_W-1:0] band_sel,
   output logic              chg,
   output logic [BANDS-1:0]  rsel
);
   logic [BSEL_W-1:0] cur;

   assign chg = (band_sel != cur);

   always_ff @(posedge clk) begin
      if (!rst_n)   cur <= '0;
      else if (chg) cur <= band_sel;
   end

   for (genvar i = 0; i < BANDS; i++) begin : g_leg
      assign rsel[i] = (cur == BSEL_W'(i));
   end

endmodule

// File: rtl/rctune_ctrl.sv
module rctune_ctrl
   import rctune_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int BANDS   = 4,
   parameter int BSEL_W  = $clog2(BANDS),
   parameter int INT_CYC = 16,
   parameter int RST_CYC = 2,
   parameter int ALT_LIM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BSEL_W-1:0] band_sel,
   input  logic              cmp_hi,
   output logic [CODE_W-1:0] ccode,
   output logic [BANDS-1:0]  rsel,
   output logic              ph_int,
   output logic              ph_cmp,
   output logic              sw_clr,
   output logic              sw_run,
   output logic              done
);
   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (BANDS < 2 || BANDS != (1 << BSEL_W)) begin : g_bad_bands
      $error("BANDS must be a power of two of at least 2");
   end
   if (INT_CYC < 1 || RST_CYC < 1) begin : g_bad_len
      $error("phase lengths must be at least one cycle");
   end
   if (ALT_LIM < 1) begin : g_bad_alt
      $error("ALT_LIM must be at least 1");
   end

   tune_ph_e ph;
   logic     decide;
   logic     conv;
   logic     chg;
   logic     restart;

   assign restart = start || chg;

   rctune_band #(.BANDS(BANDS), .BSEL_W(BSEL_W)) u_band (
      .clk(clk), .rst_n(rst_n), .band_sel(band_sel), .chg(chg), .rsel(rsel)
   );

   rctune_seq #(.INT_CYC(INT_CYC), .RST_CYC(RST_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .restart(restart), .conv(conv),
      .ph(ph), .decide(decide)
   );

   rctune_code #(.CODE_W(CODE_W), .ALT_LIM(ALT_LIM)) u_code (
      .clk(clk), .rst_n(rst_n), .restart(restart), .decide(decide),
      .up(cmp_hi), .code(ccode), .conv(conv)
   );

   always_comb begin
      {ph_int, ph_cmp, sw_clr, sw_run} = phase_drive(ph);
      done = (ph == PH_DONE);
   end

endmodule

// File: rtl/rctune_ctrl_chk.sv
module rctune_ctrl_chk #(
   parameter int CODE_W = 6,
   parameter int BANDS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              restart,
   input logic              cmp_hi,
   input logic [CODE_W-1:0] ccode,
   input logic [BANDS-1:0]  rsel,
   input logic              ph_int,
   input logic              ph_cmp,
   input logic              sw_clr,
   input logic              sw_run,
   input logic              done
);
   localparam logic [CODE_W-1:0] MAXC = '1;
   localparam logic [CODE_W-1:0] MIDC = CODE_W'(1) << (CODE_W - 1);

   // R3
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_int && ph_cmp));

   // R3
   clr_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |-> sw_run);

   // R4
   cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_cmp |=> !ph_cmp);

   // R5
   code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ccode != $past(ccode)) |->
         ($past(restart) || ($past(ph_cmp) &&
          (ccode == $past(ccode) + 1'b1 || ccode == $past(ccode) - 1'b1))));

   // R6
   sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph_cmp) && $past(cmp_hi) && $past(ccode) == MAXC && !$past(restart))
         |-> ccode == MAXC);

   // R6
   sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph_cmp) && !$past(cmp_hi) && $past(ccode) == '0 && !$past(restart))
         |-> ccode == '0);

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(ccode));

   // R8
   rsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rsel) == 1);

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (ccode == MIDC && ph_int && sw_clr && !done));

endmodule

bind rctune_ctrl rctune_ctrl_chk #(.CODE_W(CODE_W), .BANDS(BANDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .restart(restart), .cmp_hi(cmp_hi),
   .ccode(ccode), .rsel(rsel), .ph_int(ph_int), .ph_cmp(ph_cmp),
   .sw_clr(sw_clr), .sw_run(sw_run), .done(done)
);

// File: tb/rctune_ctrl_tb.sv
module rctune_ctrl_tb_top;
   localparam int RSTC = 2;
   localparam int INTC = 16;
   localparam int ALTL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] band_sel = 2'd0;
   logic       cmp_hi;
   logic [5:0] ccode;
   logic [3:0] rsel;
   logic       ph_int, ph_cmp, sw_clr, sw_run, done;
   int         cmp_mode = 0;   // 0 RC model, 1 forced high, 2 forced low

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   rctune_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .band_sel(band_sel),
      .cmp_hi(cmp_hi), .ccode(ccode), .rsel(rsel), .ph_int(ph_int),
      .ph_cmp(ph_cmp), .sw_clr(sw_clr), .sw_run(sw_run), .done(done)
   );

   function automatic int tgt_of(int b);
      case (b)
         0: return 40;
         1: return 25;
         2: return 50;
         default: return 10;
      endcase
   endfunction

   // held ramp height ~ 1/(Cmain + code); reference = 1000
   function automatic bit cmp_of(int code, int b, int mode);
      int vout;
      if (mode == 1) return 1'b1;
      if (mode == 2) return 1'b0;
      vout = (tgt_of(b) + 20) * 1000 / (20 + code);
      return vout > 1000;
   endfunction

   assign cmp_hi = cmp_of(int'(ccode), int'(band_sel), cmp_mode);

   // behavioural reference model
   int m_ph = 0;  // 0 idle 1 clear 2 integrate 3 compare 4 done
   int m_cnt = 0, m_code = 32, m_alt = 0, m_band = 0;
   bit m_have = 0, m_up = 0;

   always @(posedge clk) begin
      bit rs, upd;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_code = 32; m_alt = 0; m_band = 0;
         m_have = 0; m_up = 0;
      end else begin
         rs = start || (int'(band_sel) != m_band);
         if (rs) begin
            m_band = int'(band_sel);
            m_code = 32; m_have = 0; m_up = 0; m_alt = 0;
            m_ph = 1; m_cnt = 0;
         end else if (m_ph == 1) begin
            if (m_cnt == RSTC - 1) begin m_ph = 2; m_cnt = 0; end
            else m_cnt++;
         end else if (m_ph == 2) begin
            if (m_cnt == INTC - 1) begin m_ph = 3; m_cnt = 0; end
            else m_cnt++;
         end else if (m_ph == 3) begin
            upd = cmp_of(m_code, m_band, cmp_mode);
            if (upd && m_code < 63) m_code++;
            if (!upd && m_code > 0) m_code--;
            if (m_have && (m_up != upd)) m_alt++;
            m_have = 1; m_up = upd;
            m_ph = (m_alt == ALTL) ? 4 : 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model: R2 R3 R4 R5 R6 R7 R8 R9 R10
   always @(negedge clk) begin
      int e_drv;
      cycles++;
      if (rst_n) begin
         case (m_ph)
            1: e_drv = 4'b1011;
            2: e_drv = 4'b1001;
            3: e_drv = 4'b0100;
            default: e_drv = 4'b0011;
         endcase
         chk(int'(ccode) == m_code, "R5 model ccode", int'(ccode), m_code);
         chk(rsel == 4'(1 << m_band), "R8 model rsel", int'(rsel), 1 << m_band);
         chk(int'({ph_int, ph_cmp, sw_clr, sw_run}) == e_drv, "R3 model phase drive",
             int'({ph_int, ph_cmp, sw_clr, sw_run}), e_drv);
         chk(done == (m_ph == 4), "R7 model done", int'(done), int'(m_ph == 4));
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic run_done(input string req);
      int n = 0;
      while (!done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, req, int'(done), 1);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ccode == 6'd32, "R1 ccode", int'(ccode), 32);
      chk(rsel == 4'b0001, "R1 rsel", int'(rsel), 1);
      chk({done, ph_int, ph_cmp} == 3'b000, "R1 flags", int'({done, ph_int, ph_cmp}), 0);
      chk({sw_clr, sw_run} == 2'b11, "R1 switches", int'({sw_clr, sw_run}), 3);

      // R2 start enters clear phase
      pulse_start();
      chk({ph_int, sw_clr, sw_run} == 3'b111, "R2 clear phase",
          int'({ph_int, sw_clr, sw_run}), 7);
      repeat (RSTC) @(negedge clk);
      // R3 integrate phase
      chk({ph_int, sw_clr, sw_run} == 3'b101, "R3 integrate phase",
          int'({ph_int, sw_clr, sw_run}), 5);
      repeat (INTC) @(negedge clk);
      // R4 compare phase
      chk({ph_cmp, sw_clr, sw_run} == 3'b100, "R4 compare phase",
          int'({ph_cmp, sw_clr, sw_run}), 4);
      @(negedge clk);
      // R5 upward step (crossing at 40)
      chk(ccode == 6'd33, "R5 step up", int'(ccode), 33);
      run_done("R7 done band0");
      chk(ccode == 6'd39 || ccode == 6'd40, "R7 converged band0", int'(ccode), 40);
      repeat (5) @(negedge clk);
      chk(ccode == 6'd39 || ccode == 6'd40, "R7 frozen band0", int'(ccode), 40);

      // R9 band change while done
      band_sel = 2'd1;
      @(negedge clk);
      chk(rsel == 4'b0010, "R9 rsel band1", int'(rsel), 2);
      chk(ccode == 6'd32 && !done, "R9 restart code", int'(ccode), 32);
      run_done("R7 done band1");
      chk(ccode == 6'd24 || ccode == 6'd25, "R7 converged band1", int'(ccode), 25);

      // R9 band change mid-run
      pulse_start();
      repeat (50) @(negedge clk);
      band_sel = 2'd2;
      @(negedge clk);
      chk(rsel == 4'b0100 && ccode == 6'd32, "R9 mid-run restart", int'(ccode), 32);
      run_done("R7 done band2");
      chk(ccode == 6'd49 || ccode == 6'd50, "R7 converged band2", int'(ccode), 50);

      // R6 saturation at top
      cmp_mode = 1;
      pulse_start();
      repeat (40 * (RSTC + INTC + 1)) @(negedge clk);
      chk(ccode == 6'd63, "R6 saturate top", int'(ccode), 63);
      chk(done == 1'b0, "R6 no done without reversal", int'(done), 0);

      // R10 restart mid-run, R6 saturation at bottom
      cmp_mode = 2;
      pulse_start();
      chk(ccode == 6'd32, "R10 restart mid-run", int'(ccode), 32);
      repeat (40 * (RSTC + INTC + 1)) @(negedge clk);
      chk(ccode == 6'd0, "R6 saturate bottom", int'(ccode), 0);

      // band 3, crossing at 10
      cmp_mode = 0;
      band_sel = 2'd3;
      @(negedge clk);
      chk(rsel == 4'b1000, "R8 rsel band3", int'(rsel), 8);
      run_done("R7 done band3");
      chk(ccode == 6'd9 || ccode == 6'd10, "R7 converged band3", int'(ccode), 10);

      // R10 start while done
      pulse_start();
      chk(ccode == 6'd32 && ph_int, "R10 restart from done", int'(ccode), 32);
      run_done("R10 done again");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule